// File: doc/BRIEF.md
# 1-Wire Link Layer Bus Sampler

The sampler listens to one open-drain 1-Wire line that has already been brought into the system clock domain. It never drives the line. It measures how long each low pulse lasts, counting clock periods from the falling edge, and turns what it sees into link-layer events. The events are a bus reset, a presence response from a slave after that reset, and single data bits with their value. Each event appears as a one-cycle strobe with a 2-bit code and a bit value.

Every timing threshold is a count of clock periods. Two separate sets exist, one for standard speed and one for overdrive speed. Each set holds a bit sample point, a presence sample point and a minimum reset length. A configuration input chooses overdrive. The choice is captured at every slot-opening falling edge, so changing it part way through a slot has no effect on that slot. An extra power-strap line, where a system has one, is not connected. When overdrive is never used the clock must run at 400 kHz or more, and 1 MHz is recommended. When overdrive may be used the clock must run at 2 MHz or more, and 5 MHz is recommended. A falling edge that arrives before the current slot has been classified is flagged as a timing error.

Top module: `ow_link_sampler`

## Requirements
- R1: While rst_ni is low, and afterwards on an idle high line, evt_valid_o and timing_err_o stay 0.
- R2: A low pulse of L clock edges with 1 <= L <= BIT_T produces a bit event: code 2'b00 and evt_bit_o = 1. It is strobed on the edge where the count since the falling edge reaches BIT_T, that is, BIT_T edges after the edge that first sees the line low.
- R3: A low pulse with BIT_T < L < RST_T produces a bit event with code 2'b00 and evt_bit_o = 0. It is strobed on the edge that first sees the line high again.
- R4: A low pulse with L >= RST_T produces a reset event with code 2'b01 and evt_bit_o = 0. It is strobed on the edge that first sees the line high again.
- R5: PRES_T edges after the rise that ended a reset, a low line produces a presence event with code 2'b10, and a high line produces no event. Low activity during this window never opens a slot or flags an error. After a presence event, the line returning high produces no event.
- R6: If od_en_i = 1 on the edge that opens a slot, that slot uses the overdrive thresholds. Otherwise it uses the standard thresholds. A change of od_en_i after that edge does not affect the slot, and it does not affect the presence window that follows a reset.
- R7: A falling edge seen while a slot is still unclassified pulses timing_err_o for one cycle on that edge. A falling edge on the very edge where the count reaches BIT_T also counts as unclassified. The new slot is then timed from that falling edge.
- R8: evt_valid_o is a single-cycle strobe, and evt_bit_o is 0 for reset and presence events.
- R9: The slot counter saturates, so a low pulse longer than 2^CNT_W-1 edges still produces a reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronized bus line level |
| od_en_i | input | 1 | Overdrive speed enable, captured at slot start |
| evt_valid_o | output | 1 | Event strobe |
| evt_code_o | output | 2 | 00 bit, 01 reset, 10 presence |
| evt_bit_o | output | 1 | Bit value for bit events |
| timing_err_o | output | 1 | Falling edge before slot classification |

## Verification
Assertions check every cycle that each event agrees with the line history around it. A bit 1 needs a high sample. A bit 0 or a reset needs a low-to-high transition. A presence needs a low sample. An error needs a falling edge. The assertions also check that the speed capture changes only at a slot-opening edge and that the counter holds at saturation. Only the bench scenarios can show the threshold arithmetic: the exact strobe cycle for every pulse length at both speeds, the bit/reset boundary, the capture of the speed per slot, and that a presence pulse does not start a slot.

// File: rtl/ow_link_pkg.sv
package ow_link_pkg;
  typedef enum logic [1:0] {
    EVT_BIT   = 2'b00,
    EVT_RESET = 2'b01,
    EVT_PRES  = 2'b10
  } evt_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_HOLD,
    ST_PRES,
    ST_WAIT_HI
  } slot_st_e;
endpackage

// File: rtl/ow_edge_det.sv
module ow_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic fall_o,
  output logic rise_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b1;
    else         line_q <= line_i;
  end

  assign fall_o = line_q & ~line_i;
  assign rise_o = ~line_q & line_i;
endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= CNT_ONE;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;

  // R9: long low pulses must not wrap below the reset threshold
  p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/ow_thr_sel.sv
module ow_thr_sel #(
  parameter int CNT_W      = 10,
  parameter int STD_BIT_T  = 15,
  parameter int STD_PRES_T = 70,
  parameter int STD_RST_T  = 480,
  parameter int OD_BIT_T   = 2,
  parameter int OD_PRES_T  = 8,
  parameter int OD_RST_T   = 48,
  parameter bit HAS_OD     = 1'b1
) (
  input  logic             spd_i,
  output logic [CNT_W-1:0] bit_o,
  output logic [CNT_W-1:0] pres_o,
  output logic [CNT_W-1:0] rst_o
);
  localparam logic [CNT_W-1:0] S_BIT  = CNT_W'(STD_BIT_T);
  localparam logic [CNT_W-1:0] S_PRES = CNT_W'(STD_PRES_T);
  localparam logic [CNT_W-1:0] S_RST  = CNT_W'(STD_RST_T);
  localparam logic [CNT_W-1:0] O_BIT  = CNT_W'(OD_BIT_T);
  localparam logic [CNT_W-1:0] O_PRES = CNT_W'(OD_PRES_T);
  localparam logic [CNT_W-1:0] O_RST  = CNT_W'(OD_RST_T);

  generate
    if (HAS_OD) begin : g_two_speed
      assign bit_o  = spd_i ? O_BIT  : S_BIT;
      assign pres_o = spd_i ? O_PRES : S_PRES;
      assign rst_o  = spd_i ? O_RST  : S_RST;
    end else begin : g_std_only
      assign bit_o  = S_BIT;
      assign pres_o = S_PRES;
      assign rst_o  = S_RST;
    end
  endgenerate
endmodule

// File: rtl/ow_link_sampler.sv
module ow_link_sampler
  import ow_link_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int STD_BIT_T  = 15,
  parameter int STD_PRES_T = 70,
  parameter int STD_RST_T  = 480,
  parameter int OD_BIT_T   = 2,
  parameter int OD_PRES_T  = 8,
  parameter int OD_RST_T   = 48,
  parameter bit HAS_OD     = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       od_en_i,
  output logic       evt_valid_o,
  output logic [1:0] evt_code_o,
  output logic       evt_bit_o,
  output logic       timing_err_o
);
  logic             fall, rise, clr, load_spd, spd_q;
  logic [CNT_W-1:0] cnt_q, bit_thr, pres_thr, rst_thr;
  slot_st_e         st_q, st_d;
  logic             ev_v, ev_b, err_d;
  evt_code_e        ev_c;
  logic             evt_valid_q, evt_bit_q, err_q;
  evt_code_e        evt_code_q;

  ow_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  ow_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cnt_o  (cnt_q)
  );

  ow_thr_sel #(
    .CNT_W(CNT_W), .STD_BIT_T(STD_BIT_T), .STD_PRES_T(STD_PRES_T),
    .STD_RST_T(STD_RST_T), .OD_BIT_T(OD_BIT_T), .OD_PRES_T(OD_PRES_T),
    .OD_RST_T(OD_RST_T), .HAS_OD(HAS_OD)
  ) u_thr (
    .spd_i  (spd_q),
    .bit_o  (bit_thr),
    .pres_o (pres_thr),
    .rst_o  (rst_thr)
  );

  always_comb begin
    st_d     = st_q;
    clr      = 1'b0;
    load_spd = 1'b0;
    ev_v     = 1'b0;
    ev_c     = EVT_BIT;
    ev_b     = 1'b0;
    err_d    = 1'b0;
    case (st_q)
      ST_IDLE: if (fall) begin
        st_d = ST_SLOT; clr = 1'b1; load_spd = 1'b1;
      end
      ST_SLOT: begin
        if (fall) begin
          // fall wins over a coincident bit sample: slot still open
          err_d = 1'b1; clr = 1'b1; load_spd = 1'b1;
        end else if (cnt_q == bit_thr) begin
          if (line_i) begin
            ev_v = 1'b1; ev_b = 1'b1; st_d = ST_IDLE;
          end else begin
            st_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: if (rise) begin
        ev_v = 1'b1;
        if (cnt_q >= rst_thr) begin
          ev_c = EVT_RESET; st_d = ST_PRES; clr = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_PRES: if (cnt_q == pres_thr) begin
        if (!line_i) begin
          ev_v = 1'b1; ev_c = EVT_PRES; st_d = ST_WAIT_HI;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_WAIT_HI: if (line_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      spd_q       <= 1'b0;
      evt_valid_q <= 1'b0;
      evt_code_q  <= EVT_BIT;
      evt_bit_q   <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      if (load_spd) spd_q <= od_en_i;
      evt_valid_q <= ev_v;
      evt_code_q  <= ev_c;
      evt_bit_q   <= ev_b;
      err_q       <= err_d;
    end
  end

  assign evt_valid_o  = evt_valid_q;
  assign evt_code_o   = evt_code_q;
  assign evt_bit_o    = evt_bit_q;
  assign timing_err_o = err_q;

  // R2: a one bit needs a high line at the sample edge
  p_bit1_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_code_o == EVT_BIT && evt_bit_o) |-> $past(line_i));
  // R3: a zero bit closes on a low-to-high transition
  p_bit0_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_code_o == EVT_BIT && !evt_bit_o) |-> ($past(line_i) && !$past(line_i, 2)));
  // R4: a reset closes on a low-to-high transition
  p_reset_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_code_o == EVT_RESET) |-> ($past(line_i) && !$past(line_i, 2)));
  // R5: presence needs a low line at the sample edge
  p_pres_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_code_o == EVT_PRES) |-> !$past(line_i));
  // R6: captured speed moves only on a slot-opening falling edge
  p_spd_at_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(spd_q));
  // R7: an error flag is always caused by a falling edge
  p_err_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_err_o |-> (!$past(line_i) && $past(line_i, 2)));
  // R8: only bit events carry a value
  p_val_bits_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_code_o != EVT_BIT) |-> !evt_bit_o);
endmodule

// File: tb/ow_link_sampler_bench.sv
`timescale 1ns/1ps
module ow_link_sampler_bench;
  localparam int CW = 6;
  localparam int SB = 6,  SP = 10, SR = 20;
  localparam int OB = 2,  OP = 4,  OR = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1;
  logic       od_en = 1'b0;
  logic       evt_valid, evt_bit, terr;
  logic [1:0] evt_code;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  ow_link_sampler #(
    .CNT_W(CW), .STD_BIT_T(SB), .STD_PRES_T(SP), .STD_RST_T(SR),
    .OD_BIT_T(OB), .OD_PRES_T(OP), .OD_RST_T(OR), .HAS_OD(1'b1)
  ) u_ow_link_sampler (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .od_en_i(od_en),
    .evt_valid_o(evt_valid), .evt_code_o(evt_code), .evt_bit_o(evt_bit),
    .timing_err_o(terr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic lv(int m, int l0, int h0, int len, bit pres, int a, int b);
    int base;
    base = (l0 > 0) ? l0 + h0 : 0;
    if (l0 > 0 && m < l0) return 1'b0;
    if (m < base) return 1'b1;
    if (m < base + len) return 1'b0;
    if (pres && m >= base + len + a && m < base + len + a + b) return 1'b0;
    return 1'b1;
  endfunction

  // len: low edges of the measured pulse; l0/h0: optional earlier short pulse
  task automatic run_slot(input string req, input bit spd, input int l0, input int h0,
                          input int len, input bit pres, input bit sw);
    int bt, pt, rt, base, e1k, e2k, tot, a, b;
    logic [1:0] e1c;
    logic e1v, has2, has_err, ok, xv, xb, xe;
    logic [1:0] xc;
    string msg;
    bt = spd ? OB : SB; pt = spd ? OP : SP; rt = spd ? OR : SR;
    base = (l0 > 0) ? l0 + h0 : 0;
    has_err = (l0 > 0) && (base <= bt);
    a = 2; b = pt + 3; has2 = 1'b0; e2k = -1;
    if (len <= bt) begin e1k = base + bt; e1c = 2'b00; e1v = 1'b1; end
    else if (len < rt) begin e1k = base + len; e1c = 2'b00; e1v = 1'b0; end
    else begin
      e1k = base + len; e1c = 2'b01; e1v = 1'b0;
      if (pres) begin has2 = 1'b1; e2k = base + len + pt; end
    end
    tot = base + len + pt + b + 6;
    ok = 1'b1; msg = "";
    od_en = spd;
    @(negedge clk);
    line = lv(0, l0, h0, len, pres, a, b);
    for (int k = 0; k <= tot; k++) begin
      @(posedge clk); @(negedge clk);
      xv = (k == e1k) || (has2 && k == e2k);
      xc = (has2 && k == e2k) ? 2'b10 : e1c;
      xb = (k == e1k) ? e1v : 1'b0;
      xe = has_err && (k == base);
      if (ok && (evt_valid !== xv || terr !== xe ||
                 (xv && (evt_code !== xc || evt_bit !== xb)))) begin
        ok = 1'b0;
        msg = $sformatf("k=%0d actual v=%b c=%b b=%b e=%b expected v=%b c=%b b=%b e=%b",
                        k, evt_valid, evt_code, evt_bit, terr, xv, xc, xb, xe);
      end
      if (sw && k == 0) od_en = ~spd;
      line = lv(k + 1, l0, h0, len, pres, a, b);
    end
    od_en = spd;
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s spd=%0d len=%0d: %s", req, spd, len, msg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (evt_valid !== 1'b0 || terr !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: actual v=%b e=%b expected 0 0", evt_valid, terr);
    end
    rst_n = 1'b1;
    begin
      logic bad;
      bad = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (evt_valid !== 1'b0 || terr !== 1'b0) bad = 1'b1;
      end
      n_chk++;
      if (bad) begin
        n_bad++;
        $display("FAIL R1 idle: actual activity expected v=0 e=0");
      end
    end

    // R2 R3 R4 sweep at standard speed, R6 sweep at overdrive
    for (int l = 1; l <= 30; l++)
      run_slot(l <= SB ? "R2" : (l < SR ? "R3" : "R4"), 1'b0, 0, 0, l, 1'b0, 1'b0);
    for (int l = 1; l <= 30; l++)
      run_slot(l <= OB ? "R6 R2" : (l < OR ? "R6 R3" : "R6 R4"), 1'b1, 0, 0, l, 1'b0, 1'b0);

    // R5 presence after reset at both speeds
    run_slot("R5", 1'b0, 0, 0, SR, 1'b1, 1'b0);
    run_slot("R5", 1'b0, 0, 0, 25, 1'b1, 1'b0);
    run_slot("R5", 1'b1, 0, 0, OR, 1'b1, 1'b0);
    run_slot("R5", 1'b1, 0, 0, 12, 1'b1, 1'b0);

    // R6 speed captured at the falling edge
    run_slot("R6", 1'b0, 0, 0, 4, 1'b0, 1'b1);
    run_slot("R6", 1'b1, 0, 0, 3, 1'b0, 1'b1);
    run_slot("R6", 1'b0, 0, 0, SR, 1'b1, 1'b1);

    // R7 early falling edge
    run_slot("R7", 1'b0, 1, 1, 3, 1'b0, 1'b0);
    run_slot("R7", 1'b0, 1, 1, 12, 1'b0, 1'b0);
    run_slot("R7", 1'b1, 1, 1, 1, 1'b0, 1'b0);
    run_slot("R7", 1'b1, 1, 1, 9, 1'b1, 1'b0);

    // R9 counter saturation, R8 strobe shape covered throughout
    run_slot("R9", 1'b0, 0, 0, 80, 1'b1, 1'b0);
    run_slot("R8", 1'b1, 0, 0, 70, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule